// File: doc/BRIEF.md
# Register Load-List Sequencer with Abort Reporting

This block walks a list of 128-bit records held in memory and turns each one into a write on a model-specific register write port. A one-cycle start pulse captures a list base address, a record count, a control-region base address and the privileged-mode flag. The sequencer then fetches the records one at a time through a request/valid read port, at addresses that step by 16 bytes. Each record is checked for legality. If it passes, the sequencer issues it as a write of a 32-bit index and a 64-bit value. It then samples the fault response of the write port in that same cycle.

The first record that fails a check, or whose write faults, ends the walk. The sequencer stores the nonzero abort code 4 into the 32-bit word at byte offset 4 of the control region and reports completion with a failed status. Writes that already completed stay in place. If any completed write hit an index on the translation-flush list, one flush request pulse is issued just before completion, whichever way the walk ended.

States: IDLE (waits for start), FETCH (holds a read request until valid), CHECK (judges the captured record), WRITE (drives the register write and samples the fault), ABORT (writes the abort code), FLUSH (pulses the flush request), DONE (pulses completion). Transitions:
- IDLE→FETCH on start with a nonzero count.
- IDLE→DONE on start with a zero count.
- FETCH→CHECK on valid.
- CHECK→WRITE when the record is legal.
- CHECK→ABORT when the record is illegal.
- WRITE→ABORT on a fault.
- WRITE→FETCH when more records remain.
- WRITE→FLUSH or WRITE→DONE after the last record, depending on whether a flush is pending.
- ABORT→FLUSH or ABORT→DONE, on the same condition.
- FLUSH→DONE.
- DONE→IDLE.

Top module: `msrl_list_loader`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and wr_en_o are low. A start pulse in IDLE is accepted and busy_o is high from the next cycle until the cycle after done_o. A start pulse while busy has no effect on addresses, records or outcome.
- R2: Record k (k = 0 … count-1) is fetched strictly in ascending order at base + 16·k. The request and address are held until valid. A count of zero gives done_o with ok_o high and no fetch.
- R3: A legal record is written with wr_idx_o = record bits 31:0 and wr_data_o = record bits 127:64.
- R4: A record whose bits 63:32 are not all zero is never written and causes an abort.
- R5: A record with index C0000100h or C0000101h is never written and causes an abort.
- R6: A record whose index bits 31:8 equal 000008h (indices 800h–8FFh) is never written and causes an abort. Indices 7FFh and 900h are legal.
- R7: A record whose index is on the privileged-only list (default 0000009Bh) causes an abort when the privileged flag captured at start was low. The same record is legal when the flag was high.
- R8: A record whose index matches any blocklist slot with its valid bit set causes an abort. A slot with its valid bit clear has no effect.
- R9: When wr_fault_i is high during a write cycle, the walk aborts. Earlier writes stand and no further record is fetched.
- R10: On abort, exactly one control write is made, to ctl_base + 4 with data 4. No other control write occurs and done_o is given with ok_o low. A successful walk makes no control write.
- R11: If any completed write hit the flush list (default C0000080h, 00000277h), flush_o pulses exactly once, in the cycle directly before done_o. Otherwise flush_o stays low.
- R12: done_o is a single-cycle pulse, and ok_o in that cycle is high exactly when no record failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, honoured only in IDLE |
| base_addr_i | input | ADDR_W | Byte address of record 0 |
| count_i | input | CNT_W | Number of records |
| ctl_base_i | input | ADDR_W | Base byte address of the control region |
| in_priv_i | input | 1 | Privileged management mode active |
| blk_idx_i | input | NBLK*32 | Blocklist indices, slot g in bits 32g+31:32g |
| blk_vld_i | input | NBLK | Blocklist slot valid bits |
| mem_req_o | output | 1 | Record read request |
| mem_addr_o | output | ADDR_W | Record read address |
| mem_vld_i | input | 1 | Read data valid |
| mem_data_i | input | 128 | Read record |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 32 | Register index |
| wr_data_o | output | 64 | Register value |
| wr_fault_i | input | 1 | Write would fault, valid while wr_en_o is high |
| ctl_we_o | output | 1 | Control-region write strobe |
| ctl_addr_o | output | ADDR_W | Control-region write address |
| ctl_data_o | output | 32 | Abort code |
| flush_o | output | 1 | Translation flush request pulse |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Completion pulse |
| ok_o | output | 1 | Completion status, valid with done_o |

## Verification
The write-fault judgement and the end-of-list decision fall in the same WRITE cycle. The bench provokes this by faulting the final record of a list, so a correct design must abort rather than complete. A flush-list index is also made to fault, so the pending-flush update and the abort meet in that one cycle. The behavioural model predicts the issued writes, the control write, the flush pulse and the status from the list alone, and compares them against the ports on every clock.

// File: rtl/msrl_pkg.sv
package msrl_pkg;
    localparam int IDX_W = 32;
    localparam int VAL_W = 64;
    localparam int ENT_W = 128;
    localparam logic [IDX_W-1:0] IDX_SEG_F = 32'hC000_0100;
    localparam logic [IDX_W-1:0] IDX_SEG_G = 32'hC000_0101;
    localparam logic [23:0]      APIC_WIN  = 24'h00_0008;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_WRITE, S_ABORT, S_FLUSH, S_DONE
    } seq_state_t;
endpackage

// File: rtl/msrl_entry_check.sv
module msrl_entry_check
    import msrl_pkg::*;
#(
    parameter int NBLK = 8,
    parameter int NPRIV = 1,
    parameter logic [NPRIV*32-1:0] PRIV_LIST = 32'h0000_009B
) (
    input  logic [63:0]          ent_lo_i,
    input  logic                 in_priv_i,
    input  logic [NBLK*32-1:0]   blk_idx_i,
    input  logic [NBLK-1:0]      blk_vld_i,
    output logic                 fail_o
);
    logic [IDX_W-1:0] idx;
    logic [NBLK-1:0]  blk_hit;
    logic [NPRIV-1:0] priv_hit;

    assign idx = ent_lo_i[IDX_W-1:0];

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        assign blk_hit[g] = blk_vld_i[g] && (blk_idx_i[g*32 +: 32] == idx);
    end

    for (genvar p = 0; p < NPRIV; p++) begin : g_priv
        assign priv_hit[p] = (PRIV_LIST[p*32 +: 32] == idx);
    end

    always_comb begin
        fail_o = 1'b0;
        if (ent_lo_i[63:32] != '0)                    fail_o = 1'b1;
        if (idx == IDX_SEG_F || idx == IDX_SEG_G)      fail_o = 1'b1;
        if (idx[31:8] == APIC_WIN)                     fail_o = 1'b1;
        if ((|priv_hit) && !in_priv_i)                 fail_o = 1'b1;
        if (|blk_hit)                                  fail_o = 1'b1;
    end
endmodule

// File: rtl/msrl_flush_detect.sv
module msrl_flush_detect
    import msrl_pkg::*;
#(
    parameter int NFL = 2,
    parameter logic [NFL*32-1:0] FLUSH_LIST = {32'h0000_0277, 32'hC000_0080}
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             need_o
);
    logic [NFL-1:0] hit;

    for (genvar f = 0; f < NFL; f++) begin : g_fl
        assign hit[f] = (FLUSH_LIST[f*32 +: 32] == idx_i);
    end

    assign need_o = |hit;
endmodule

// File: rtl/msrl_list_loader.sv
module msrl_list_loader
    import msrl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W = 9,
    parameter int NBLK = 8,
    parameter logic [31:0] ABORT_CODE = 32'd4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   base_addr_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [ADDR_W-1:0]   ctl_base_i,
    input  logic                in_priv_i,
    input  logic [NBLK*32-1:0]  blk_idx_i,
    input  logic [NBLK-1:0]     blk_vld_i,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic                mem_vld_i,
    input  logic [ENT_W-1:0]    mem_data_i,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_idx_o,
    output logic [VAL_W-1:0]    wr_data_o,
    input  logic                wr_fault_i,
    output logic                ctl_we_o,
    output logic [ADDR_W-1:0]   ctl_addr_o,
    output logic [31:0]         ctl_data_o,
    output logic                flush_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                ok_o
);
    localparam int ENT_BYTES = ENT_W / 8;
    localparam int ENT_SHIFT = $clog2(ENT_BYTES);
    localparam logic [ADDR_W-1:0] CODE_OFS = ADDR_W'(4);

    seq_state_t         state_q, state_d;
    logic [ADDR_W-1:0]  base_q, ctl_q;
    logic [CNT_W-1:0]   cnt_q, idx_q, idx_nxt;
    logic               priv_q, pend_q, ok_q;
    logic [ENT_W-1:0]   ent_q;
    logic               chk_fail, need_fl, last_ent;

    msrl_entry_check #(.NBLK(NBLK)) u_check (
        .ent_lo_i  (ent_q[63:0]),
        .in_priv_i (priv_q),
        .blk_idx_i (blk_idx_i),
        .blk_vld_i (blk_vld_i),
        .fail_o    (chk_fail)
    );

    msrl_flush_detect u_flush (
        .idx_i  (ent_q[IDX_W-1:0]),
        .need_o (need_fl)
    );

    assign idx_nxt  = idx_q + 1'b1;
    assign last_ent = (idx_nxt == cnt_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = (count_i == '0) ? S_DONE : S_FETCH;
            S_FETCH: if (mem_vld_i) state_d = S_CHECK;
            S_CHECK: state_d = chk_fail ? S_ABORT : S_WRITE;
            S_WRITE: begin
                if (wr_fault_i)    state_d = S_ABORT;
                else if (last_ent) state_d = (pend_q || need_fl) ? S_FLUSH : S_DONE;
                else               state_d = S_FETCH;
            end
            S_ABORT: state_d = pend_q ? S_FLUSH : S_DONE;
            S_FLUSH: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0; ctl_q <= '0; cnt_q <= '0; idx_q <= '0;
            priv_q <= 1'b0; pend_q <= 1'b0; ok_q <= 1'b1; ent_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    base_q <= base_addr_i;
                    ctl_q  <= ctl_base_i;
                    cnt_q  <= count_i;
                    priv_q <= in_priv_i;
                    idx_q  <= '0;
                    pend_q <= 1'b0;
                    ok_q   <= 1'b1;
                end
                S_FETCH: if (mem_vld_i) ent_q <= mem_data_i;
                S_CHECK: if (chk_fail) ok_q <= 1'b0;
                S_WRITE: begin
                    if (wr_fault_i) ok_q <= 1'b0;
                    else begin
                        if (need_fl) pend_q <= 1'b1;
                        idx_q <= idx_nxt;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req_o  = (state_q == S_FETCH);
        mem_addr_o = base_q + (ADDR_W'(idx_q) << ENT_SHIFT);
        wr_en_o    = (state_q == S_WRITE);
        wr_idx_o   = ent_q[IDX_W-1:0];
        wr_data_o  = ent_q[ENT_W-1:64];
        ctl_we_o   = (state_q == S_ABORT);
        ctl_addr_o = ctl_q + CODE_OFS;
        ctl_data_o = ABORT_CODE;
        flush_o    = (state_q == S_FLUSH);
        busy_o     = (state_q != S_IDLE);
        done_o     = (state_q == S_DONE);
        ok_o       = ok_q;
    end

    // Legality checks R4 R5 R6 R7 R8: no write for a rejected record
    assert_wr_only_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !chk_fail);

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_vld_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_single_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_o |=> (!ctl_we_o && (flush_o || done_o)));

    assert_code_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_o |-> (ctl_data_o != 32'd0));

    assert_flush_before_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> done_o);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ok_means_no_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> !$past(ctl_we_o));
endmodule

// File: tb/msrl_list_loader_tb.sv
module msrl_list_loader_tb_top;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          start_i = 1'b0;
    logic [31:0]   base_addr_i = '0;
    logic [8:0]    count_i = '0;
    logic [31:0]   ctl_base_i = '0;
    logic          in_priv_i = 1'b0;
    logic [NB*32-1:0] blk_idx_i;
    logic [NB-1:0] blk_vld_i;
    logic          mem_req_o, mem_vld_i = 1'b0;
    logic [31:0]   mem_addr_o;
    logic [127:0]  mem_data_i = '0;
    logic          wr_en_o, wr_fault_i = 1'b0;
    logic [31:0]   wr_idx_o;
    logic [63:0]   wr_data_o;
    logic          ctl_we_o, flush_o, busy_o, done_o, ok_o;
    logic [31:0]   ctl_addr_o, ctl_data_o;

    logic [31:0] blk_tab [NB];
    logic        blk_on  [NB];
    always_comb begin
        for (int g = 0; g < NB; g++) begin
            blk_idx_i[g*32 +: 32] = blk_tab[g];
            blk_vld_i[g]          = blk_on[g];
        end
    end

    msrl_list_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .count_i(count_i), .ctl_base_i(ctl_base_i), .in_priv_i(in_priv_i),
        .blk_idx_i(blk_idx_i), .blk_vld_i(blk_vld_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_vld_i(mem_vld_i),
        .mem_data_i(mem_data_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
        .wr_data_o(wr_data_o), .wr_fault_i(wr_fault_i), .ctl_we_o(ctl_we_o),
        .ctl_addr_o(ctl_addr_o), .ctl_data_o(ctl_data_o), .flush_o(flush_o),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit c, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!c) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model state
    logic [127:0] ent [8];
    logic [31:0]  exp_base, exp_ctl, fault_idx;
    bit           fault_en, smm, exp_ok, exp_flush, mon_on, done_seen;
    int           exp_n, exp_issue, wpos, lat_cnt, flush_cnt, ctl_cnt;

    function automatic bit is_bad(logic [127:0] e, bit s);
        logic [31:0] ix = e[31:0];
        bit b = 0;
        if (e[63:32] != 0) b = 1;
        if (ix == 32'hC000_0100 || ix == 32'hC000_0101) b = 1;
        if (ix >= 32'h800 && ix <= 32'h8FF) b = 1;
        if (ix == 32'h9B && !s) b = 1;
        for (int g = 0; g < NB; g++) if (blk_on[g] && blk_tab[g] == ix) b = 1;
        return b;
    endfunction

    function automatic bit is_fl(logic [31:0] ix);
        return (ix == 32'hC000_0080) || (ix == 32'h0000_0277);
    endfunction

    task automatic predict();
        exp_issue = 0; exp_ok = 1; exp_flush = 0;
        for (int k = 0; k < exp_n; k++) begin
            if (is_bad(ent[k], smm)) begin exp_ok = 0; break; end
            exp_issue = k + 1;
            if (fault_en && ent[k][31:0] == fault_idx) begin exp_ok = 0; break; end
            if (is_fl(ent[k][31:0])) exp_flush = 1;
        end
    endtask

    // Per-clock monitor and responder
    always @(negedge clk) begin
        wr_fault_i = 1'b0;
        if (mon_on) begin
            if (mem_req_o) begin
                chk(mem_addr_o == exp_base + 32'(16 * wpos), "R2 fetch address", mem_addr_o, exp_base + 32'(16 * wpos));
                chk(wpos < exp_n && wpos <= exp_issue, "R9 fetch within walk", wpos, exp_issue);
                if (lat_cnt >= (wpos % 3)) begin
                    mem_vld_i = 1'b1;
                    mem_data_i = ent[wpos % 8];
                end else begin
                    lat_cnt++;
                end
            end else begin
                mem_vld_i = 1'b0;
                lat_cnt = 0;
            end
            if (wr_en_o) begin
                chk(wpos < exp_issue, "R4 write only legal records", wpos, exp_issue);
                chk(wr_idx_o == ent[wpos % 8][31:0], "R3 write index", wr_idx_o, ent[wpos % 8][31:0]);
                chk(wr_data_o == ent[wpos % 8][127:64], "R3 write value", wr_data_o, ent[wpos % 8][127:64]);
                wr_fault_i = fault_en && (wr_idx_o == fault_idx);
                wpos++;
            end
            if (ctl_we_o) begin
                chk(!exp_ok, "R10 control write only on abort", 1, 0);
                chk(ctl_addr_o == exp_ctl + 4, "R10 code address", ctl_addr_o, exp_ctl + 4);
                chk(ctl_data_o == 32'd4, "R10 code value", ctl_data_o, 4);
                ctl_cnt++;
            end
            if (flush_o) begin
                chk(exp_flush, "R11 flush expected", 1, exp_flush);
                flush_cnt++;
            end
            if (done_o) begin
                chk(ok_o == exp_ok, "R12 status", ok_o, exp_ok);
                chk(wpos == exp_issue, "R9 writes issued", wpos, exp_issue);
                chk(flush_cnt == int'(exp_flush), "R11 flush count", flush_cnt, exp_flush);
                chk(ctl_cnt == int'(!exp_ok), "R10 control writes", ctl_cnt, !exp_ok);
                done_seen = 1;
                mon_on = 0;
            end
        end else begin
            mem_vld_i = 1'b0;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run(input logic [31:0] b, input int n, input bit s, input bit poke);
        int guard;
        exp_base = b; exp_ctl = b + 32'h1000; exp_n = n; smm = s;
        predict();
        wpos = 0; lat_cnt = 0; flush_cnt = 0; ctl_cnt = 0; done_seen = 0;
        @(negedge clk);
        mon_on = 1;
        base_addr_i = b; count_i = 9'(n); in_priv_i = s; ctl_base_i = exp_ctl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; in_priv_i = !s;
        #1 chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            base_addr_i = 32'h0000_9000; count_i = 9'd1; start_i = 1'b1;   // R1: ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (!done_seen && guard < 500) begin
            @(negedge clk);
            #1 guard++;
        end
        if (!done_seen) begin
            chk(0, "watchdog done_o", 0, 1);
            finish_run();
        end
        @(negedge clk);
        #1 chk(busy_o == 1'b0, "R1 idle after done", busy_o, 0);
    endtask

    function automatic logic [127:0] rec(logic [31:0] ix, logic [31:0] rs, logic [63:0] v);
        return {v, rs, ix};
    endfunction

    initial begin
        for (int g = 0; g < NB; g++) begin blk_tab[g] = 32'h0; blk_on[g] = 1'b0; end
        for (int k = 0; k < 8; k++) ent[k] = '0;
        fault_en = 0; fault_idx = 0; mon_on = 0;
        repeat (3) @(negedge clk);
        #1 chk(!busy_o && !done_o && !mem_req_o && !wr_en_o, "R1 reset state", {busy_o, done_o, mem_req_o, wr_en_o}, 0);
        rst_n = 1'b1;

        // R2 R3 R6 legal list incl. 7FF and 900 boundaries, R1 start while busy
        ent[0] = rec(32'h10, 0, 64'h1111_2222_3333_4444);
        ent[1] = rec(32'h7FF, 0, 64'hAAAA_0000_5555_0001);
        ent[2] = rec(32'h900, 0, 64'h0123_4567_89AB_CDEF);
        run(32'h0000_4000, 3, 0, 1);
        // R2 zero count
        run(32'h0000_5000, 0, 0, 0);
        // R4 reserved bits
        ent[1] = rec(32'h20, 32'h1, 64'h5);
        run(32'h0000_6000, 3, 0, 0);
        // R5 both segment-base indices
        ent[0] = rec(32'hC000_0101, 0, 64'h7);
        run(32'h0000_6100, 2, 0, 0);
        ent[0] = rec(32'h10, 0, 64'h7); ent[1] = rec(32'h11, 0, 64'h8);
        ent[2] = rec(32'hC000_0100, 0, 64'h9);
        run(32'h0000_6200, 3, 0, 0);
        // R6 window interior
        ent[1] = rec(32'h8A5, 0, 64'h9);
        run(32'h0000_6300, 3, 0, 0);
        // R7 privileged-only index
        ent[1] = rec(32'h9B, 0, 64'h42); ent[2] = rec(32'h12, 0, 64'h43);
        run(32'h0000_6400, 3, 0, 0);
        run(32'h0000_6500, 3, 1, 0);
        // R8 blocklist valid vs invalid slot
        blk_tab[3] = 32'h1234; blk_on[3] = 1'b1;
        ent[1] = rec(32'h1234, 0, 64'h44);
        run(32'h0000_6600, 3, 1, 0);
        blk_on[3] = 1'b0;
        run(32'h0000_6700, 3, 1, 0);
        // R9 fault on the last record (fault meets end-of-list)
        fault_en = 1; fault_idx = 32'h55;
        ent[0] = rec(32'h30, 0, 64'h1); ent[1] = rec(32'h31, 0, 64'h2); ent[2] = rec(32'h55, 0, 64'h3);
        run(32'h0000_6800, 3, 0, 0);
        // R11 flush on success
        fault_en = 0;
        ent[0] = rec(32'hC000_0080, 0, 64'h501); ent[1] = rec(32'h31, 0, 64'h2);
        run(32'h0000_6900, 2, 0, 0);
        // R11 flush then abort on a later bad record
        ent[1] = rec(32'h850, 0, 64'h2);
        run(32'h0000_6A00, 3, 0, 0);
        // R11 flush-list write that faults: no flush
        fault_en = 1; fault_idx = 32'h277;
        ent[0] = rec(32'h40, 0, 64'h1); ent[1] = rec(32'h277, 0, 64'h2);
        run(32'h0000_6B00, 2, 0, 0);
        fault_en = 0;

        finish_run();
    end
endmodule